// File: doc/BRIEF.md
# Bounded Triangle Compare Sweeper

This block moves two 16-bit compare values back and forth between per-channel limits. The result is that two PWM duty cycles rise and fall in a triangle pattern with no software involvement. A one-cycle tick pulse, typically the PWM period interrupt, drives it. On every eleventh tick both compare values move by one step. Each channel has its own direction and its own lower and upper limit.

The two outputs are meant to be written into the shadow compare registers of a PWM. A one-cycle update pulse marks each change of the outputs.

A load strobe captures four things for each channel: the limits, the starting value and the starting direction. The same strobe restarts the tick count.

The limit checks are not symmetric:

- Moving upward, a channel steps up only while it is below its upper limit. Otherwise it turns around and steps down in the same update, so a channel can overshoot by one step.
- Moving downward, a channel turns around only when it is exactly at its lower limit. A channel that starts below that limit keeps falling and wraps through zero.

Top module: `tri_cmp_sweep`

## Requirements
- R1: While reset is asserted and after it is released, both compare outputs read 0 and the update pulse is low until the first load. Reset asserts asynchronously and is released on a clock edge through a two-stage synchronizer.
- R2: A clock edge with `load_i` high captures, for each channel, the lower limit, the upper limit, the start value and the start direction. A direction bit of 1 means upward and 0 means downward. From the next cycle the outputs show the start values.
- R3: A load clears the tick count. When a load and a tick come in the same cycle, the load wins and that tick is not counted.
- R4: A step happens on the clock edge that samples the 11th tick since the last load. Ticks may be separated by any number of idle cycles. Ten ticks leave the outputs unchanged.
- R5: On a step, a channel moving upward whose value is below its upper limit increases by one and keeps its direction.
- R6: On a step, a channel moving upward whose value is equal to or above its upper limit switches to downward and decreases by one in the same step.
- R7: On a step, a channel moving downward whose value equals its lower limit switches to upward and increases by one. Any other value, including one below the lower limit, decreases by one and wraps from 0 to 65535.
- R8: Both channels step on the same tick, each by its own direction and limits.
- R9: `upd_o` is high for exactly the one cycle in which new output values first appear after a load or a step. The compare outputs do not change in any cycle where `upd_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick pulse, one per PWM period |
| load_i | input | 1 | Captures limits and start state, and clears the tick count |
| a_lo_i | input | 16 | Channel A lower limit |
| a_hi_i | input | 16 | Channel A upper limit |
| a_init_i | input | 16 | Channel A start value |
| a_up_i | input | 1 | Channel A start direction (1 = upward) |
| b_lo_i | input | 16 | Channel B lower limit |
| b_hi_i | input | 16 | Channel B upper limit |
| b_init_i | input | 16 | Channel B start value |
| b_up_i | input | 1 | Channel B start direction (1 = upward) |
| cmp_a_o | output | 16 | Channel A compare value |
| cmp_b_o | output | 16 | Channel B compare value |
| upd_o | output | 1 | One-cycle pulse marking new compare values |

## Verification
A reload and a tick can land in the same clock cycle. The interesting case is when the tick count already stands at ten, so that the coincident tick would otherwise cause a step. The bench provokes this by applying ten ticks and then raising the load and the eleventh tick together with new start values.

It judges the outcome in three ways:

- The outputs must show exactly the new start values.
- The next ten ticks must cause no step.
- The step must come on the eleventh tick after the load.

A second coincidence is also driven: both channels turning around in the same step.

// File: rtl/sweep_pkg.sv
`timescale 1ns/1ps
package sweep_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } sweep_dir_e;

  localparam int unsigned LANE_A    = 0;
  localparam int unsigned LANE_B    = 1;
  localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/sweep_rst_sync.sv
`timescale 1ns/1ps
module sweep_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sweep_tick_div.sv
`timescale 1ns/1ps
module sweep_tick_div #(
  parameter int unsigned DIV = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic step_o
);

  localparam int unsigned CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  // Next-state: a clear dominates, otherwise each tick advances or wraps.
  always_comb begin
    cnt_en = clear_i | tick_i;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign step_o = tick_i & ~clear_i & at_last;

endmodule

// File: rtl/sweep_lane.sv
`timescale 1ns/1ps
module sweep_lane
  import sweep_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] init_i,
  input  logic         up_i,
  output logic [W-1:0] val_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] lo_q, hi_q, val_q;
  logic [W-1:0] lo_d, hi_d, val_d;
  sweep_dir_e   dir_q, dir_d;
  logic         lane_en;

  always_comb begin
    lane_en = load_i | step_i;
    lo_d    = lo_q;
    hi_d    = hi_q;
    val_d   = val_q;
    dir_d   = dir_q;
    if (load_i) begin
      lo_d  = lo_i;
      hi_d  = hi_i;
      val_d = init_i;
      dir_d = up_i ? DIR_UP : DIR_DOWN;
    end else if (step_i) begin
      if (dir_q == DIR_UP) begin
        // Upward: climb while under the ceiling, else turn and fall now.
        if (val_q < hi_q) begin
          val_d = val_q + ONE;
        end else begin
          dir_d = DIR_DOWN;
          val_d = val_q - ONE;
        end
      end else begin
        // Downward: only an exact hit on the floor turns the lane around.
        if (val_q == lo_q) begin
          dir_d = DIR_UP;
          val_d = val_q + ONE;
        end else begin
          val_d = val_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      val_q <= '0;
      dir_q <= DIR_UP;
    end else if (lane_en) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      val_q <= val_d;
      dir_q <= dir_d;
    end
  end

  assign val_o = val_q;

endmodule

// File: rtl/tri_cmp_sweep.sv
`timescale 1ns/1ps
module tri_cmp_sweep
  import sweep_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned TICK_DIV = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] a_lo_i,
  input  logic [W-1:0] a_hi_i,
  input  logic [W-1:0] a_init_i,
  input  logic         a_up_i,
  input  logic [W-1:0] b_lo_i,
  input  logic [W-1:0] b_hi_i,
  input  logic [W-1:0] b_init_i,
  input  logic         b_up_i,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o,
  output logic         upd_o
);

  logic rst_core_n;
  logic step;
  logic upd_d, upd_q;

  logic [W-1:0] lo_arr   [NUM_LANES];
  logic [W-1:0] hi_arr   [NUM_LANES];
  logic [W-1:0] init_arr [NUM_LANES];
  logic [W-1:0] val_arr  [NUM_LANES];
  logic         up_arr   [NUM_LANES];

  sweep_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sweep_tick_div #(.DIV(TICK_DIV)) u_tick_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clear_i (load_i),
    .tick_i  (tick_i),
    .step_o  (step)
  );

  assign lo_arr[LANE_A]   = a_lo_i;
  assign hi_arr[LANE_A]   = a_hi_i;
  assign init_arr[LANE_A] = a_init_i;
  assign up_arr[LANE_A]   = a_up_i;
  assign lo_arr[LANE_B]   = b_lo_i;
  assign hi_arr[LANE_B]   = b_hi_i;
  assign init_arr[LANE_B] = b_init_i;
  assign up_arr[LANE_B]   = b_up_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sweep_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .load_i (load_i),
      .step_i (step),
      .lo_i   (lo_arr[g]),
      .hi_i   (hi_arr[g]),
      .init_i (init_arr[g]),
      .up_i   (up_arr[g]),
      .val_o  (val_arr[g])
    );
  end

  assign upd_d = load_i | step;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  assign cmp_a_o = val_arr[LANE_A];
  assign cmp_b_o = val_arr[LANE_B];
  assign upd_o   = upd_q;

endmodule

// File: rtl/sweep_chk.sv
`timescale 1ns/1ps
module sweep_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         load_i,
  input logic [W-1:0] a_init_i,
  input logic [W-1:0] b_init_i,
  input logic [W-1:0] cmp_a_o,
  input logic [W-1:0] cmp_b_o,
  input logic         upd_o
);

  // R9: outputs only move in a cycle flagged by the update pulse
  assert_hold_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(cmp_a_o) && $stable(cmp_b_o)));

  // R9: a pulse needs a load or a tick in the cycle before it
  assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(tick_i || load_i));

  // R9: a pulse not followed by a load cannot repeat in the next cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !load_i) |=> !upd_o);

  // R2: the cycle after a load shows the start values
  assert_load_values_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && $past(load_i)) |-> (cmp_a_o == $past(a_init_i) && cmp_b_o == $past(b_init_i)));

  // R8: a step moves both channels by exactly one
  assert_step_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !$past(load_i)) |->
      ((cmp_a_o == $past(cmp_a_o) + W'(1) || cmp_a_o == $past(cmp_a_o) - W'(1)) &&
       (cmp_b_o == $past(cmp_b_o) + W'(1) || cmp_b_o == $past(cmp_b_o) - W'(1))));

endmodule

bind tri_cmp_sweep sweep_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .load_i   (load_i),
  .a_init_i (a_init_i),
  .b_init_i (b_init_i),
  .cmp_a_o  (cmp_a_o),
  .cmp_b_o  (cmp_b_o),
  .upd_o    (upd_o)
);

// File: tb/tri_cmp_sweep_tb.sv
`timescale 1ns/1ps
module tri_cmp_sweep_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_i, load_i;
  logic [W-1:0] a_lo_i, a_hi_i, a_init_i, b_lo_i, b_hi_i, b_init_i;
  logic         a_up_i, b_up_i;
  logic [W-1:0] cmp_a_o, cmp_b_o;
  logic         upd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tri_cmp_sweep #(.W(W), .TICK_DIV(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
    .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .a_init_i(a_init_i), .a_up_i(a_up_i),
    .b_lo_i(b_lo_i), .b_hi_i(b_hi_i), .b_init_i(b_init_i), .b_up_i(b_up_i),
    .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int ea, input int eb, input int eu);
    chk(req, "cmp_a", int'(cmp_a_o), ea);
    chk(req, "cmp_b", int'(cmp_b_o), eb);
    chk(req, "upd",   int'(upd_o),   eu);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  // Applies ticks; the output check happens at the negedge right after the last tick edge.
  task automatic step_once(input int gap);
    ticks(10, gap);
    for (int i = 0; i < 1; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic load_cfg(input int alo, input int ahi, input int ai, input bit aup,
                          input int blo, input int bhi, input int bi, input bit bup,
                          input bit with_tick);
    @(negedge clk);
    a_lo_i = W'(alo); a_hi_i = W'(ahi); a_init_i = W'(ai); a_up_i = aup;
    b_lo_i = W'(blo); b_hi_i = W'(bhi); b_init_i = W'(bi); b_up_i = bup;
    load_i = 1'b1; tick_i = with_tick;
    @(negedge clk);
    load_i = 1'b0; tick_i = 1'b0;
    chk_out("R2", ai, bi, 1);
    @(negedge clk);
    chk("R9", "upd after load", int'(upd_o), 0);
  endtask

  task automatic t_reset();
    chk_out("R1", 0, 0, 0);
    repeat (5) @(negedge clk);
    chk_out("R1", 0, 0, 0);
  endtask

  task automatic t_basic();
    load_cfg(50, 950, 50, 1'b1, 1050, 1950, 1950, 1'b0, 1'b0);
    ticks(10, 0);
    chk_out("R4", 50, 1950, 0);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    chk_out("R5", 51, 1949, 1);
    @(negedge clk);
    chk_out("R9", 51, 1949, 0);
    step_once(3);
    chk_out("R4", 52, 1948, 1);
    step_once(1);
    chk_out("R8", 53, 1947, 1);
  endtask

  task automatic t_turn();
    load_cfg(50, 52, 51, 1'b1, 10, 20, 12, 1'b0, 1'b0);
    step_once(0); chk_out("R5", 52, 11, 1);
    step_once(0); chk_out("R6", 51, 10, 1);
    step_once(0); chk_out("R7", 50, 11, 1);
    step_once(0); chk_out("R7", 51, 12, 1);
  endtask

  task automatic t_outside();
    load_cfg(10, 52, 60, 1'b1, 10, 20, 0, 1'b0, 1'b0);
    step_once(0); chk_out("R6", 59, 65535, 1);
    step_once(0); chk_out("R7", 58, 65534, 1);
  endtask

  task automatic t_collide();
    load_cfg(100, 200, 150, 1'b1, 300, 400, 350, 1'b0, 1'b0);
    ticks(10, 0);
    chk_out("R3", 150, 350, 0);
    load_cfg(100, 200, 120, 1'b0, 300, 400, 390, 1'b1, 1'b1);
    ticks(10, 1);
    chk_out("R3", 120, 390, 0);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    chk_out("R3", 119, 391, 1);
  endtask

  task automatic t_both_flip();
    load_cfg(0, 3, 3, 1'b1, 7, 9, 7, 1'b0, 1'b0);
    step_once(0); chk_out("R8", 2, 8, 1);
    @(negedge clk);
    chk_out("R9", 2, 8, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; load_i = 1'b0;
    a_lo_i = '0; a_hi_i = '0; a_init_i = '0; a_up_i = 1'b0;
    b_lo_i = '0; b_hi_i = '0; b_init_i = '0; b_up_i = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_turn();
    t_outside();
    t_collide();
    t_both_flip();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule